// File: doc/BRIEF.md
# Count/Compare Timer Interrupt Unit

This block is a processor-style timer. A 32-bit counter advances by one on each cycle where a one-cycle tick strobe is high, and a 32-bit compare register holds a target value. When an increment carries the counter onto the compare value, the block latches a timer interrupt. The interrupt drives one of eight output lines, and a 3-bit select input picks the line. It can also record a pending flag, but only when the feature-enable input allows it.

Software loads either register through a single write port and reads the live counter value on a dedicated output. A freeze input stops the counter from advancing, but a write still loads it. Any write to the compare register acknowledges the interrupt, which clears both the latched line and the pending flag.

Top module: `cc_timer`

## Requirements
- R1: On each clock edge where `tick` is high, `freeze` is low and no counter write is present, `count_q` increments by one modulo 2^32, so 0xFFFFFFFF becomes 0. `count_q` holds on edges without the strobe.
- R2: While `freeze` is high, `count_q` does not advance on a tick. A counter write (`wr_en`=1, `wr_sel`=0) still loads `wr_data`.
- R3: An edge that increments the counter onto the compare value raises the interrupt, which is visible right after that edge. A counter write that makes the counter equal to compare raises nothing, and so does a tick while frozen.
- R4: The interrupt fires once per equality event. After an acknowledge, a counter held at the compare value does not raise it again.
- R5: A compare write (`wr_en`=1, `wr_sel`=1) loads compare and clears both `pending` and `irq_lines` after that edge. If the same edge also produces a match, the result is cleared.
- R6: While the interrupt is active, `irq_lines` equals 1 shifted left by `line_sel`, and all other lines are 0. It follows `line_sel` combinationally and is never more than one-hot.
- R7: After reset, `count_q` is 1, compare is 0, and `pending` and `irq_lines` are 0.
- R8: `pending` is set by a match only when `rec_en` is high. When `rec_en` is low, the match drives the line alone.
- R9: A counter write takes priority over an increment on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle count strobe |
| freeze | input | 1 | Stops counter advance |
| rec_en | input | 1 | Allows the pending flag to be recorded |
| line_sel | input | 3 | Selects the interrupt output line |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 counter, 1 compare |
| wr_data | input | 32 | Write value |
| count_q | output | 32 | Current counter value |
| pending | output | 1 | Recorded timer-interrupt pending flag |
| irq_lines | output | 8 | Interrupt outputs, at most one high |

## Verification
The embedded properties are evaluated on every cycle. They cover increment and hold of the counter, freezing, counter-write priority, clearing on an acknowledge, the one-hot shape of the output lines, and the rule that a rising pending flag requires the recording enable. A rising line is also checked to coincide with counter equal to compare. Other behaviour needs directed scenarios: wrap at the top of the range, the absence of a refire while the counter sits at the compare value, the same-edge acknowledge-versus-match case, a write that lands on the compare value, and steering to a particular line number.

// File: rtl/cc_timer.sv
module cc_timer #(
  parameter int WIDTH = 32,
  parameter int LINES = 8,
  parameter int SELW  = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             freeze,
  input  logic             rec_en,
  input  logic [SELW-1:0]  line_sel,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] count_q,
  output logic             pending,
  output logic [LINES-1:0] irq_lines
);
  localparam logic [WIDTH-1:0] CNT_INIT = WIDTH'(1);

  logic [WIDTH-1:0] cmp_q;
  logic             line_q;
  logic             pend_q;

  wire cnt_wr  = wr_en && !wr_sel;
  wire cmp_wr  = wr_en &&  wr_sel;
  wire advance = tick && !freeze && !cnt_wr;
  wire [WIDTH-1:0] cnt_inc = count_q + WIDTH'(1);
  wire match   = advance && (cnt_inc == cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= CNT_INIT;
      cmp_q   <= '0;
      line_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (cnt_wr)       count_q <= wr_data;
      else if (advance) count_q <= cnt_inc;

      if (cmp_wr) cmp_q <= wr_data;

      if (cmp_wr) begin
        line_q <= 1'b0;
        pend_q <= 1'b0;
      end else if (match) begin
        line_q <= 1'b1;
        if (rec_en) pend_q <= 1'b1;
      end
    end
  end

  assign pending   = pend_q;
  assign irq_lines = line_q ? (LINES'(1) << line_sel) : '0;

  a_r1_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !freeze && !(wr_en && !wr_sel)) |=> count_q == $past(count_q) + WIDTH'(1));

  a_r2_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !(wr_en && !wr_sel)) |=> count_q == $past(count_q));

  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> count_q == $past(wr_data));

  a_r3_rise_on_equal: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_q) |-> count_q == cmp_q);

  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (!pending && irq_lines == '0));

  a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_lines));

  a_r8_record_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(rec_en));
endmodule

// File: tb/cc_timer_test.sv
module cc_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, freeze = 1'b0, rec_en = 1'b1;
  logic [2:0]  line_sel = 3'd0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] count_q;
  logic        pending;
  logic [7:0]  irq_lines;
  int checks = 0, fails = 0;

  cc_timer uut (.clk(clk), .rst_n(rst_n), .tick(tick), .freeze(freeze), .rec_en(rec_en),
    .line_sel(line_sel), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .count_q(count_q), .pending(pending), .irq_lines(irq_lines));

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one edge with given strobes; starts and ends at a negedge
  task automatic cyc(input logic t, input logic we, input logic sel, input logic [31:0] d);
    tick = t; wr_en = we; wr_sel = sel; wr_data = d;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R7 count", count_q, 32'd1);
    chk("R7 pending", {31'd0, pending}, 0);
    chk("R7 lines", {24'd0, irq_lines}, 0);
    cyc(1, 0, 0, 0);
    chk("R7 compare 0 no match at 2", {24'd0, irq_lines}, 0);
  endtask

  task automatic t_increment;
    cyc(0, 1, 0, 32'd10);
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0);
    chk("R1 three ticks", count_q, 32'd13);
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    chk("R1 hold without strobe", count_q, 32'd13);
    cyc(0, 1, 0, 32'hFFFF_FFFF);
    cyc(1, 0, 0, 0);
    chk("R1 wrap", count_q, 32'd0);
  endtask

  task automatic t_freeze;
    cyc(0, 1, 0, 32'd40);
    freeze = 1'b1;
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
    chk("R2 frozen tick", count_q, 32'd40);
    cyc(0, 1, 0, 32'd5);
    chk("R2 write while frozen", count_q, 32'd5);
    cyc(0, 1, 1, 32'd6);
    cyc(1, 0, 0, 0);
    chk("R3 no match while frozen", {24'd0, irq_lines}, 0);
    freeze = 1'b0;
  endtask

  task automatic t_match;
    rec_en = 1'b1; line_sel = 3'd3;
    cyc(0, 1, 1, 32'd10);
    cyc(0, 1, 0, 32'd8);
    cyc(1, 0, 0, 0);
    chk("R3 no early fire", {24'd0, irq_lines}, 0);
    cyc(1, 0, 0, 0);
    chk("R3 count at compare", count_q, 32'd10);
    chk("R6 line 3", {24'd0, irq_lines}, 32'h08);
    chk("R3 pending", {31'd0, pending}, 1);
    line_sel = 3'd5; #1;
    chk("R6 line 5", {24'd0, irq_lines}, 32'h20);
    cyc(1, 0, 0, 0);
    chk("R3 latched past match", {24'd0, irq_lines}, 32'h20);
    cyc(0, 1, 0, 32'd10);
    cyc(0, 1, 1, 32'd10);
    chk("R5 ack clears lines", {24'd0, irq_lines}, 0);
    chk("R5 ack clears pending", {31'd0, pending}, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0);
    chk("R4 held equal no refire", {24'd0, irq_lines}, 0);
  endtask

  task automatic t_same_edge;
    cyc(0, 1, 1, 32'd20);
    cyc(0, 1, 0, 32'd19);
    cyc(1, 1, 1, 32'd20);
    chk("R5 same edge count", count_q, 32'd20);
    chk("R5 same edge cleared", {24'd0, irq_lines}, 0);
    chk("R5 same edge pending", {31'd0, pending}, 0);
  endtask

  task automatic t_norecord;
    rec_en = 1'b0; line_sel = 3'd7;
    cyc(0, 1, 1, 32'd50);
    cyc(0, 1, 0, 32'd49);
    cyc(1, 0, 0, 0);
    chk("R8 line driven", {24'd0, irq_lines}, 32'h80);
    chk("R8 no pending", {31'd0, pending}, 0);
    cyc(0, 1, 1, 32'd0);
    rec_en = 1'b1;
  endtask

  task automatic t_priority;
    line_sel = 3'd0;
    cyc(0, 1, 1, 32'd31);
    cyc(0, 1, 0, 32'd30);
    cyc(1, 1, 0, 32'd100);
    chk("R9 write beats tick", count_q, 32'd100);
    chk("R9 no match from skipped inc", {24'd0, irq_lines}, 0);
    cyc(0, 1, 1, 32'd200);
    cyc(0, 1, 0, 32'd200);
    chk("R3 write onto compare no fire", {24'd0, irq_lines}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_increment();
    t_freeze();
    t_match();
    t_same_edge();
    t_norecord();
    t_priority();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule